// File: doc/BRIEF.md
# Boot Core Selection Register

This block is one 8-bit control and status register on a plain internal register bus, decoded at register index 0x10. Firmware uses it to choose which stored configuration image (a "core") the device should reload itself from, and to request that reload. Reading it returns the stored core number together with the live, synchronized state of two front-panel buttons: a drive button and an M1 button.

A new core number is taken from a write only while the device is in configuration mode, and only when the number does not exceed the highest supported core (a parameter). Any other number leaves the stored value alone. Software can therefore find the highest supported core by writing a number and reading it back. Setting the top bit of a write sends a one-cycle reboot request to the reconfiguration engine. The request carries the core number as it stands after that same write. In normal running, pressing either button raises a one-cycle non-maskable interrupt request toward the CPU. The reconfiguration engine and the CPU are outside this block.

Top module: `boot_core_ctrl`

## Requirements
- R1: After synchronous reset the stored core number is 2, so a read of index 0x10 with no button held returns 0x08.
- R2: Read data bit 7 is always 0. Bits 6..2 carry the stored core number, bit 1 the drive button and bit 0 the M1 button.
- R3: In configuration mode (cfg_mode=1), a write to index 0x10 with bits 4..0 at or below MAX_ID stores bits 4..0. The new value shows at the next clock.
- R4: In normal mode (cfg_mode=0), a write to index 0x10 leaves the stored core number unchanged.
- R5: A write whose bits 4..0 exceed MAX_ID (default 23) is dropped and the old core number is kept. A value equal to MAX_ID is accepted.
- R6: A write to index 0x10 with bit 7 set, in either mode, makes reboot_req high for exactly the one cycle after the write edge. In that cycle reboot_core shows the core number that results from the same write.
- R7: Writes to any other index change nothing, and reads of any other index return 0x00.
- R8: Each button input passes through a two-flop synchronizer. A level on the input shows in the read data two clock edges later.
- R9: In normal mode, a rising edge of either synchronized button produces a one-cycle nmi_req, three edges after the raw input rises. A held button produces no further pulse.
- R10: No nmi_req is raised while cfg_mode is 1.
- R11: Bits 6..5 of write data have no effect on the stored core number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 1 = configuration mode, 0 = normal running |
| reg_addr | input | 8 | Register index for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| btn_drive | input | 1 | Raw drive button, active high |
| btn_m1 | input | 1 | Raw M1 button, active high |
| reboot_req | output | 1 | One-cycle request to reconfigure |
| reboot_core | output | 5 | Core number to boot into |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The bench targets the range limit at both sides of MAX_ID. A design with an off-by-one comparison would drop 23 or accept 24. It checks that normal-mode writes do nothing, which a design that ignores cfg_mode would fail by changing the number, and that reserved bits 6..5 do not leak into the stored value. It checks that a reboot write made together with a new core number reports the new number, not the old one, and that back-to-back reboot writes give back-to-back pulses. For the buttons it watches the exact cycle of the read-back level and of the interrupt pulse. A missing synchronizer stage shows up one cycle early, a level-triggered interrupt stays high while the button is held, and a missing mode gate fires an interrupt in configuration mode.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    localparam int CORE_ID_W   = 5;
    localparam int REG_DATA_W  = 8;
    localparam int NUM_BUTTONS = 2;
    localparam int BTN_M1_IDX    = 0;
    localparam int BTN_DRIVE_IDX = 1;

    typedef logic [CORE_ID_W-1:0]   core_id_t;
    typedef logic [NUM_BUTTONS-1:0] btn_vec_t;

    // write word: start flag, two reserved bits, requested core number
    typedef struct packed {
        logic       start;
        logic [1:0] rsv;
        core_id_t   id;
    } sel_wr_t;

    // read word: zero bit, stored core number, button levels
    typedef struct packed {
        logic     zero;
        core_id_t id;
        btn_vec_t btn;
    } sel_rd_t;

    function automatic logic id_accepted(core_id_t id, int unsigned max_id);
        return int'(id) <= int'(max_id);
    endfunction

endpackage

// File: rtl/btn_sync_edge.sv
module btn_sync_edge #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_btn
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[b]};
                prev  <= chain[LAST];
            end
        end

        assign level[b] = chain[LAST];
        assign rise[b]  = chain[LAST] & ~prev;
    end

endmodule

// File: rtl/core_sel_reg.sv
module core_sel_reg
    import boot_sel_pkg::*;
#(
    parameter int unsigned MAX_ID   = 23,
    parameter int unsigned RESET_ID = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_hit,
    input  logic     cfg_mode,
    input  core_id_t wr_id,
    output core_id_t core_id
);
    localparam core_id_t RESET_VAL = core_id_t'(RESET_ID);

    logic take;

    always_comb begin
        take = wr_hit && cfg_mode && id_accepted(wr_id, MAX_ID);
    end

    always_ff @(posedge clk) begin
        if (rst)       core_id <= RESET_VAL;
        else if (take) core_id <= wr_id;
    end

endmodule

// File: rtl/reboot_strobe.sv
module reboot_strobe (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic start_bit,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= wr_hit & start_bit;
    end
endmodule

// File: rtl/boot_core_ctrl.sv
module boot_core_ctrl
    import boot_sel_pkg::*;
#(
    parameter logic [7:0]  REG_INDEX   = 8'h10,
    parameter int unsigned MAX_ID      = 23,
    parameter int unsigned RESET_ID    = 2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_mode,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       btn_drive,
    input  logic       btn_m1,
    output logic       reboot_req,
    output logic [4:0] reboot_core,
    output logic       nmi_req
);
    sel_wr_t  wword;
    sel_rd_t  rword;
    logic     hit;
    logic     wr_hit;
    btn_vec_t btn_raw;
    btn_vec_t btn_level;
    btn_vec_t btn_rise;
    core_id_t core_id;
    logic     nmi_q;

    always_comb begin
        wword  = sel_wr_t'(reg_wdata);
        hit    = (reg_addr == REG_INDEX);
        wr_hit = reg_wr && hit;
        btn_raw = '0;
        btn_raw[BTN_DRIVE_IDX] = btn_drive;
        btn_raw[BTN_M1_IDX]    = btn_m1;
    end

    btn_sync_edge #(.WIDTH(NUM_BUTTONS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn_raw),
        .level (btn_level),
        .rise  (btn_rise)
    );

    core_sel_reg #(.MAX_ID(MAX_ID), .RESET_ID(RESET_ID)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .cfg_mode (cfg_mode),
        .wr_id    (wword.id),
        .core_id  (core_id)
    );

    reboot_strobe u_rb (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .start_bit (wword.start),
        .req       (reboot_req)
    );

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= (|btn_rise) & ~cfg_mode;
    end

    always_comb begin
        rword.zero = 1'b0;
        rword.id   = core_id;
        rword.btn  = btn_level;
        reg_rdata  = hit ? REG_DATA_W'(rword) : '0;
    end

    assign reboot_core = core_id;
    assign nmi_req     = nmi_q;

endmodule

// File: rtl/boot_core_ctrl_chk.sv
module boot_core_ctrl_chk #(
    parameter logic [7:0]  REG_INDEX = 8'h10,
    parameter int unsigned MAX_ID    = 23,
    parameter int unsigned RESET_ID  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_mode,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       reboot_req,
    input logic [4:0] reboot_core,
    input logic       nmi_req
);
    AST_RESET_ID: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reboot_core == 5'(RESET_ID));                              // R1
    AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == 1'b0);                                                    // R2
    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !cfg_mode) |=> $stable(reboot_core));                          // R4
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(reboot_core) <= int'(MAX_ID));                                       // R5
    AST_REBOOT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> $past(reg_wr && reg_addr == REG_INDEX && reg_wdata[7]));   // R6
    AST_OTHER_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != REG_INDEX) |=> $stable(reboot_core) && !reboot_req); // R7
    AST_NMI_GATED: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> !$past(cfg_mode));                                            // R10
endmodule

bind boot_core_ctrl boot_core_ctrl_chk #(
    .REG_INDEX (REG_INDEX),
    .MAX_ID    (MAX_ID),
    .RESET_ID  (RESET_ID)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_mode    (cfg_mode),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .reboot_req  (reboot_req),
    .reboot_core (reboot_core),
    .nmi_req     (nmi_req)
);

// File: tb/test_boot_core_ctrl.sv
module test_boot_core_ctrl;
    localparam int CLK_P = 10;
    localparam logic [7:0] IDX = 8'h10;
    localparam int MAXI = 23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_mode = 1'b0;
    logic [7:0] reg_addr = IDX;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       btn_drive = 1'b0;
    logic       btn_m1 = 1'b0;
    logic       reboot_req;
    logic [4:0] reboot_core;
    logic       nmi_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string id_tag = "R1";

    // reference state
    int         exp_id = 2;
    bit         exp_rb = 1'b0;
    bit         exp_nmi = 1'b0;
    logic [1:0] hist [4] = '{2'b00, 2'b00, 2'b00, 2'b00};

    always #(CLK_P/2) clk = ~clk;

    boot_core_ctrl i_boot_core_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .btn_drive(btn_drive), .btn_m1(btn_m1), .reboot_req(reboot_req),
        .reboot_core(reboot_core), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, updated on each edge, compared a quarter period later
    always @(posedge clk) begin
        logic [7:0] exp_rd;
        if (rst) begin
            exp_id  = 2;
            exp_rb  = 1'b0;
            exp_nmi = 1'b0;
            for (int i = 0; i < 4; i++) hist[i] = 2'b00;
        end else begin
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {btn_drive, btn_m1};
            exp_nmi = (|(hist[2] & ~hist[3])) && !cfg_mode;
            exp_rb  = reg_wr && reg_addr == IDX && reg_wdata[7];
            if (reg_wr && reg_addr == IDX && cfg_mode && int'(reg_wdata[4:0]) <= MAXI)
                exp_id = int'(reg_wdata[4:0]);
        end
        #(CLK_P/4);
        if (!rst) begin
            exp_rd = (reg_addr == IDX) ? {1'b0, 5'(exp_id), hist[1]} : 8'h00;
            if (reg_addr == IDX) begin
                chk("R2", "rdata bit7", int'(reg_rdata[7]), 0);
                chk(id_tag, "rdata core", int'(reg_rdata[6:2]), int'(exp_rd[6:2]));
                chk("R8", "rdata buttons", int'(reg_rdata[1:0]), int'(exp_rd[1:0]));
            end else begin
                chk("R7", "rdata other index", int'(reg_rdata), 0);
            end
            chk("R6", "reboot_req", int'(reboot_req), int'(exp_rb));
            if (reboot_req) chk("R6", "reboot_core", int'(reboot_core), exp_id);
            chk(cfg_mode ? "R10" : "R9", "nmi_req", int'(nmi_req), int'(exp_nmi));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = IDX;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(posedge clk); #(CLK_P/4);
        chk("R1", "reset read", int'(reg_rdata), 8'h08);
        chk("R1", "reset core", int'(reboot_core), 2);
        idle(2);

        cfg_mode = 1'b1;
        id_tag = "R3"; wr(IDX, 8'h05); idle(1);
        chk("R3", "stored 5", int'(reboot_core), 5);
        id_tag = "R5"; wr(IDX, 8'h1F); idle(1);
        chk("R5", "31 dropped", int'(reboot_core), 5);
        wr(IDX, 8'h17); idle(1);
        chk("R5", "23 taken", int'(reboot_core), 23);
        wr(IDX, 8'h18); idle(1);
        chk("R5", "24 dropped", int'(reboot_core), 23);
        id_tag = "R11"; wr(IDX, 8'h63); idle(1);
        chk("R11", "reserved ignored", int'(reboot_core), 3);

        cfg_mode = 1'b0;
        id_tag = "R4"; wr(IDX, 8'h09); idle(1);
        chk("R4", "normal hold", int'(reboot_core), 3);
        id_tag = "R6"; wr(IDX, 8'h80); idle(1);
        cfg_mode = 1'b1;
        wr(IDX, 8'h8C);
        @(negedge clk); reg_addr = IDX; reg_wdata = 8'h87; reg_wr = 1'b1;
        @(negedge clk); reg_wdata = 8'h81;
        @(negedge clk); reg_wr = 1'b0;
        idle(2);
        chk("R6", "back-to-back result", int'(reboot_core), 1);

        id_tag = "R7"; wr(8'h11, 8'h0A);
        reg_addr = 8'h11; idle(2); reg_addr = IDX; idle(1);
        chk("R7", "other index write", int'(reboot_core), 1);

        cfg_mode = 1'b0; id_tag = "R2";
        @(negedge clk); btn_drive = 1'b1; idle(6);
        btn_drive = 1'b0; idle(4);
        btn_m1 = 1'b1; idle(2); btn_drive = 1'b1; idle(5);
        btn_m1 = 1'b0; btn_drive = 1'b0; idle(4);
        cfg_mode = 1'b1;
        btn_m1 = 1'b1; idle(6); btn_m1 = 1'b0; idle(4);
        cfg_mode = 1'b0;
        btn_m1 = 1'b1; idle(1); btn_m1 = 1'b0; idle(6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule